// File: doc/BRIEF.md
# Double-Block Packed Byte SAD Unit

This block is a vector execution datapath. It computes sums of absolute differences (SAD) between unsigned bytes for motion-search style kernels. It takes two vector sources of width `VL` (128, 256 or 512 bits). The second source is first reordered at 32-bit granularity inside every 128-bit lane, under an 8-bit shuffle control. Every 64-bit superblock of the result then holds four 16-bit SADs. Each SAD compares a fixed four-byte group of the first source with a four-byte window that slides across the reordered vector.

The raw results pass through a write-mask stage that works per 16-bit word. A cleared mask bit either keeps the old destination word or forces it to zero, depending on the mode. The outcome is captured in an output register and flagged with `out_valid` one cycle after `in_valid`. The destination port is `MAX_VL` bits wide, and every bit above `VL` reads as zero. `VL` is a parameter, and an unsupported value stops elaboration.

Top module: `dbsad_unit`

## Requirements
- R1: For each 128-bit lane, reordered dword k (k = 0..3) equals the second-source dword of the same lane whose index is held in `shuf_ctrl[2k+1:2k]`. The same control byte applies to all lanes.
- R2: Word 0 of each 64-bit superblock is the sum of |A[n] − T[n]| for n = 0..3. A is the first-source byte n of the superblock and T is the reordered byte n.
- R3: Word 1 of each superblock is the sum of |A[n] − T[n+1]| for n = 0..3.
- R4: Word 2 of each superblock is the sum of |A[4+n] − T[2+n]|, and word 3 is the sum of |A[4+n] − T[3+n]|, for n = 0..3.
- R5: Every SAD lies in 0..1020. It is zero-extended into its 16-bit word without saturation, so all-0x00 against all-0xFF gives 0x03FC in every word.
- R6: When `mask_en` is 0, or `wmask[j]` is 1, result word j takes the computed SAD.
- R7: When `mask_en` is 1, `wmask[j]` is 0 and `zero_mode` is 0 (merge), result word j equals word j of `old_dst`.
- R8: When `mask_en` is 1, `wmask[j]` is 0 and `zero_mode` is 1, result word j is zero.
- R9: `dst` bits from `VL` up to `MAX_VL-1` always read zero.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `dst` changes only in those cycles and otherwise holds its value.
- R11: After reset, `out_valid` is 0 and `dst` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_a | input | VL | First source (stationary byte groups) |
| src_b | input | VL | Second source (reordered per lane) |
| shuf_ctrl | input | 8 | Four 2-bit dword selectors |
| wmask | input | VL/16 | Per-word write mask |
| mask_en | input | 1 | 1 = apply `wmask` |
| zero_mode | input | 1 | 1 = masked words become zero, 0 = merge |
| old_dst | input | VL | Previous destination for merging |
| out_valid | output | 1 | Result valid |
| dst | output | MAX_VL | Registered result, zero above VL |

## Verification
The bench sweeps all 256 shuffle controls on random data, which exposes a lane that reuses the wrong selector field or reads across a lane boundary. All-0x00 against all-0xFF operands push every SAD to 1020: a sum truncated to 8 bits, or a saturating adder, shows up as a value other than 0x03FC. Random masks in merge mode and in zero mode catch swapped modes or a mask bit applied to the wrong word. An off-by-one window offset in words 1 to 3 fails the random comparisons against the bench's own sliding-window model.

// File: rtl/dbsad_pkg.sv
package dbsad_pkg;
  localparam int LANE_W = 128;
  localparam int SB_W   = 64;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int DW_W   = 32;

  // Absolute difference of two unsigned bytes
  function automatic logic [7:0] absdiff8(input logic [7:0] x, input logic [7:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  // Sum of four byte-wise absolute differences, zero-extended to a word
  function automatic logic [15:0] sad4(input logic [31:0] grp, input logic [31:0] win);
    logic [9:0] acc;
    acc = '0;
    for (int n = 0; n < 4; n++) begin
      acc = acc + {2'b00, absdiff8(grp[n*8 +: 8], win[n*8 +: 8])};
    end
    return {6'd0, acc};
  endfunction

  // Pick one of four dwords of a lane
  function automatic logic [31:0] pick_dword(input logic [127:0] lane, input logic [1:0] sel);
    case (sel)
      2'd0:    return lane[31:0];
      2'd1:    return lane[63:32];
      2'd2:    return lane[95:64];
      default: return lane[127:96];
    endcase
  endfunction
endpackage

// File: rtl/dbsad_lane_shuffle.sv
module dbsad_lane_shuffle
  import dbsad_pkg::*;
(
  input  logic [LANE_W-1:0] lane_in,
  input  logic [7:0]        ctrl,
  output logic [LANE_W-1:0] lane_out
);
  for (genvar k = 0; k < 4; k++) begin : g_dw
    assign lane_out[k*DW_W +: DW_W] = pick_dword(lane_in, ctrl[2*k +: 2]);
  end
endmodule

// File: rtl/dbsad_superblock.sv
module dbsad_superblock
  import dbsad_pkg::*;
(
  input  logic [SB_W-1:0] a_blk,
  input  logic [SB_W-1:0] t_blk,
  output logic [SB_W-1:0] sad_blk
);
  // word w: fixed group (low for w<2, high otherwise) vs window at byte offset w
  for (genvar w = 0; w < 4; w++) begin : g_word
    logic [DW_W-1:0] grp;
    logic [DW_W-1:0] win;
    assign grp = (w < 2) ? a_blk[31:0] : a_blk[63:32];
    assign win = t_blk[w*BYTE_W +: DW_W];
    assign sad_blk[w*WORD_W +: WORD_W] = sad4(grp, win);
  end
endmodule

// File: rtl/dbsad_mask_stage.sv
module dbsad_mask_stage
  import dbsad_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int W = WORDS * WORD_W
) (
  input  logic [W-1:0]     res,
  input  logic [W-1:0]     old,
  input  logic [WORDS-1:0] mask,
  input  logic             mask_en,
  input  logic             zero_mode,
  output logic [W-1:0]     merged
);
  for (genvar j = 0; j < WORDS; j++) begin : g_w
    logic take;
    assign take = !mask_en || mask[j];
    assign merged[j*WORD_W +: WORD_W] = take      ? res[j*WORD_W +: WORD_W] :
                                        zero_mode ? '0 : old[j*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/dbsad_unit.sv
module dbsad_unit
  import dbsad_pkg::*;
#(
  parameter int VL     = 256,
  parameter int MAX_VL = 512,
  localparam int LANES = VL / LANE_W,
  localparam int SBS   = VL / SB_W,
  localparam int KL    = VL / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VL-1:0]     src_a,
  input  logic [VL-1:0]     src_b,
  input  logic [7:0]        shuf_ctrl,
  input  logic [KL-1:0]     wmask,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic [VL-1:0]     old_dst,
  output logic              out_valid,
  output logic [MAX_VL-1:0] dst
);
  if (!(VL == 128 || VL == 256 || VL == 512) || MAX_VL < VL) begin : g_bad_vl
    $error("dbsad_unit: unsupported VL/MAX_VL");
  end

  logic [VL-1:0] shuf_vec;
  logic [VL-1:0] sad_vec;
  logic [VL-1:0] masked_vec;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dbsad_lane_shuffle u_shuf (
      .lane_in  (src_b[l*LANE_W +: LANE_W]),
      .ctrl     (shuf_ctrl),
      .lane_out (shuf_vec[l*LANE_W +: LANE_W])
    );
  end

  for (genvar s = 0; s < SBS; s++) begin : g_sb
    dbsad_superblock u_sb (
      .a_blk   (src_a[s*SB_W +: SB_W]),
      .t_blk   (shuf_vec[s*SB_W +: SB_W]),
      .sad_blk (sad_vec[s*SB_W +: SB_W])
    );
  end

  dbsad_mask_stage #(.WORDS(KL)) u_mask (
    .res       (sad_vec),
    .old       (old_dst),
    .mask      (wmask),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .merged    (masked_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) dst <= MAX_VL'(masked_vec);
    end
  end
endmodule

// File: rtl/dbsad_unit_chk.sv
module dbsad_unit_chk #(
  parameter int VL     = 256,
  parameter int MAX_VL = 512,
  localparam int KL    = VL / 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [KL-1:0]     wmask,
  input logic              mask_en,
  input logic              zero_mode,
  input logic [VL-1:0]     old_dst,
  input logic [VL-1:0]     sad_vec,
  input logic              out_valid,
  input logic [MAX_VL-1:0] dst
);
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst));
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dst >> VL) == '0);

  for (genvar j = 0; j < KL; j++) begin : g_w
    assert_sad_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sad_vec[j*16 +: 16] <= 16'd1020);
    assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (!mask_en || wmask[j])) |=> dst[j*16 +: 16] == $past(sad_vec[j*16 +: 16]));
    assert_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_en && !wmask[j] && !zero_mode) |=> dst[j*16 +: 16] == $past(old_dst[j*16 +: 16]));
    assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_en && !wmask[j] && zero_mode) |=> dst[j*16 +: 16] == 16'd0);
  end
endmodule

bind dbsad_unit dbsad_unit_chk #(.VL(VL), .MAX_VL(MAX_VL)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wmask(wmask),
  .mask_en(mask_en), .zero_mode(zero_mode), .old_dst(old_dst),
  .sad_vec(sad_vec), .out_valid(out_valid), .dst(dst)
);

// File: tb/dbsad_unit_tb_top.sv
`timescale 1ns/1ps
module dbsad_unit_tb_top;
  localparam int VL = 256;
  localparam int MAX_VL = 512;
  localparam int KL = VL / 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [VL-1:0] src_a = '0, src_b = '0, old_dst = '0;
  logic [7:0] shuf_ctrl = '0;
  logic [KL-1:0] wmask = '0;
  logic mask_en = 1'b0, zero_mode = 1'b0;
  logic out_valid;
  logic [MAX_VL-1:0] dst;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dbsad_unit #(.VL(VL), .MAX_VL(MAX_VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .shuf_ctrl(shuf_ctrl), .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode),
    .old_dst(old_dst), .out_valid(out_valid), .dst(dst)
  );

  // Reference: reorder per lane, then sliding-window sums, then masking
  function automatic logic [MAX_VL-1:0] model(
    input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [7:0] c,
    input logic [KL-1:0] m, input logic me, input logic zm, input logic [VL-1:0] od);
    logic [VL-1:0] t;
    logic [MAX_VL-1:0] r;
    r = '0;
    for (int l = 0; l < VL/128; l++)
      for (int k = 0; k < 4; k++) begin
        int sel;
        sel = int'(c[2*k +: 2]);
        t[l*128 + k*32 +: 32] = b[l*128 + sel*32 +: 32];
      end
    for (int s = 0; s < VL/64; s++)
      for (int w = 0; w < 4; w++) begin
        int sum, ab, tb, g, idx;
        sum = 0;
        g = (w < 2) ? 0 : 4;
        for (int n = 0; n < 4; n++) begin
          ab = int'(a[s*64 + (g+n)*8 +: 8]);
          tb = int'(t[s*64 + (w+n)*8 +: 8]);
          sum += (ab > tb) ? ab - tb : tb - ab;
        end
        idx = s*4 + w;
        if (!me || m[idx]) r[idx*16 +: 16] = 16'(sum);
        else if (zm)       r[idx*16 +: 16] = 16'd0;
        else               r[idx*16 +: 16] = od[idx*16 +: 16];
      end
    return r;
  endfunction

  task automatic check_vec(input string req, input logic [MAX_VL-1:0] act, input logic [MAX_VL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_op(input string req, input logic [VL-1:0] a, input logic [VL-1:0] b,
                        input logic [7:0] c, input logic [KL-1:0] m, input logic me,
                        input logic zm, input logic [VL-1:0] od);
    logic [MAX_VL-1:0] exp;
    @(negedge clk);
    src_a = a; src_b = b; shuf_ctrl = c; wmask = m;
    mask_en = me; zero_mode = zm; old_dst = od; in_valid = 1'b1;
    exp = model(a, b, c, m, me, zm, od);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R10 out_valid after op", out_valid, 1'b1);
    check_vec(req, dst, exp);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [MAX_VL-1:0] held;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R11: reset state
    check_bit("R11 out_valid reset", out_valid, 1'b0);
    check_vec("R11 dst reset", dst, '0);
    rst_n = 1'b1;

    // R5: extremes, every shuffle value
    for (int c = 0; c < 256; c++)
      run_op("R5 00 vs FF", '0, '1, 8'(c), '0, 1'b0, 1'b0, '0);
    run_op("R5 FF vs 00", '1, '0, 8'hE4, '0, 1'b0, 1'b0, '0);
    check_vec("R5 word value", dst, {{(MAX_VL-VL){1'b0}}, {KL{16'h03FC}}});

    // R1: every shuffle value on random data
    for (int c = 0; c < 256; c++)
      run_op("R1 shuffle", rnd_vec(), rnd_vec(), 8'(c), '0, 1'b0, 1'b0, '0);

    // R2, R3, R4: window positions on random data with identity and reversed control
    run_op("R2 word0 window", rnd_vec(), rnd_vec(), 8'hE4, '0, 1'b0, 1'b0, '0);
    run_op("R3 word1 window", rnd_vec(), rnd_vec(), 8'h1B, '0, 1'b0, 1'b0, '0);
    for (int i = 0; i < 60; i++)
      run_op("R4 words2-3 window", rnd_vec(), rnd_vec(), 8'($urandom), '0, 1'b0, 1'b0, '0);

    // R6: unmasked ignores wmask; all-ones mask passes
    run_op("R6 mask disabled", rnd_vec(), rnd_vec(), 8'($urandom), '0, 1'b0, 1'b1, rnd_vec());
    run_op("R6 mask all ones", rnd_vec(), rnd_vec(), 8'($urandom), '1, 1'b1, 1'b1, rnd_vec());

    // R7 merge and R8 zero with random masks
    for (int i = 0; i < 40; i++) begin
      run_op("R7 merge mode", rnd_vec(), rnd_vec(), 8'($urandom), KL'($urandom), 1'b1, 1'b0, rnd_vec());
      run_op("R8 zero mode", rnd_vec(), rnd_vec(), 8'($urandom), KL'($urandom), 1'b1, 1'b1, rnd_vec());
    end
    run_op("R7 merge all masked", rnd_vec(), rnd_vec(), 8'h00, '0, 1'b1, 1'b0, '1);
    run_op("R8 zero all masked", '1, '0, 8'hFF, '0, 1'b1, 1'b1, '1);

    // R9: bits above VL
    run_op("R9 op", '0, '1, 8'h55, '1, 1'b1, 1'b0, '1);
    check_vec("R9 upper zero", dst >> VL, '0);

    // R10: hold while idle
    held = dst;
    repeat (3) @(negedge clk);
    check_bit("R10 out_valid idle", out_valid, 1'b0);
    src_a = rnd_vec(); src_b = rnd_vec();
    @(negedge clk);
    check_vec("R10 dst hold", dst, held);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule